// File: doc/BRIEF.md
# History-Indexed Two-Bit Branch Predictor

This block guesses the direction of conditional branches. Each static branch owns a private group of 2-bit saturating state machines, and a global outcome history register, shared by every branch, picks one state inside that group. The history length is a parameter of 0, 1 or 2 bits, so a branch owns 1, 2 or 4 states.

A lookup presents a branch slot and at once receives a taken or not-taken guess. The guess comes from the state that the slot and the current history select. A resolve presents a slot and its real outcome. At the next clock edge the block moves the selected state one step toward that outcome, counts a miss if the state's guess was wrong, and then shifts the outcome into the history. Lookups and resolves are independent and may happen in the same cycle.

Top module: `hist_branch_predictor`

## Requirements
- R1: A synchronous active-high reset sets every state to 2'b10 and the history to all zeros and clears the miss count. After reset every lookup returns not-taken.
- R2: A state whose upper bit is 1 predicts not-taken (pred_taken = 0). A state whose upper bit is 0 predicts taken (pred_taken = 1).
- R3: On a taken resolve the selected state steps 10 -> 11 -> 00 -> 01 and stays at 01.
- R4: On a not-taken resolve the selected state steps 01 -> 00 -> 11 -> 10 and stays at 10.
- R5: Each resolve shifts the outcome (1 taken, 0 not-taken) into history bit 0, and the older bits move up one place. One history register serves all branches. Without a resolve the history holds.
- R6: With HIST_BITS = h, the state used is the one of the slot's 2^h states whose set number equals the history value. With h = 0 each slot has a single state.
- R7: A resolve updates the state selected by the history as it stood before that resolve's own shift.
- R8: A resolve changes only the state it selects. States of other slots, and other sets of the same slot, are unchanged.
- R9: miss_count rises by one on each resolve where the selected state's guess (by R2, before the update) differs from the outcome. It saturates at its maximum and is unchanged in cycles without a resolve.
- R10: A lookup in the same cycle as a resolve returns the value from before that resolve's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lkp_slot | input | SLOT_W | Branch slot being looked up |
| pred_taken | output | 1 | Predicted direction of the looked-up slot (1 = taken) |
| res_valid | input | 1 | A branch outcome is being resolved this cycle |
| res_slot | input | SLOT_W | Slot of the resolving branch |
| res_taken | input | 1 | Actual outcome (1 = taken) |
| miss_count | output | CNT_W | Saturating count of mispredicted resolves |

## Verification
A short hand-worked sequence on fresh states first checks that the same slot gives different answers under different histories. It also checks that a slot's state moves only when that exact history value comes round again, which separates correct set selection and update-before-shift from a design that indexes with the shifted history. A loop of two branches follows: one branch alternates and the other is always taken. This is the case where history makes the alternating branch predictable, and it exposes wrong history ordering. Long runs of one direction on one slot check saturation at both ends. A long pseudo-random mix of lookups and resolves, often on the same slot in the same cycle, is compared with a behavioural model on every cycle. A reset in the middle of a run must restore the initial guesses and count.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef logic [1:0] bp_state_t;

    // Initial value: weakest-trust not-taken end of the chain
    localparam bp_state_t BP_INIT = 2'b10;

    typedef enum logic {
        DIR_NOT_TAKEN = 1'b0,
        DIR_TAKEN     = 1'b1
    } bp_dir_e;

    // Upper bit clear means taken
    function automatic bp_dir_e bp_guess(bp_state_t s);
        return s[1] ? DIR_NOT_TAKEN : DIR_TAKEN;
    endfunction

    // Map state onto a linear confidence level 0 (strong NT) .. 3 (strong T)
    function automatic logic [1:0] bp_level(bp_state_t s);
        return {~s[1], s[0]};
    endfunction

    function automatic bp_state_t bp_from_level(logic [1:0] lvl);
        return {~lvl[1], lvl[0]};
    endfunction

    function automatic bp_state_t bp_step(bp_state_t s, bp_dir_e dir);
        logic [1:0] lvl;
        lvl = bp_level(s);
        if (dir == DIR_TAKEN) begin
            if (lvl != 2'd3) lvl = lvl + 2'd1;
        end else begin
            if (lvl != 2'd0) lvl = lvl - 2'd1;
        end
        return bp_from_level(lvl);
    endfunction

endpackage

// File: rtl/bp_history.sv
module bp_history #(
    parameter int HIST_BITS = 2,
    localparam int HW = (HIST_BITS == 0) ? 1 : HIST_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_en,
    input  logic          shift_bit,
    output logic [HW-1:0] hist_o
);

    generate
        if (HIST_BITS == 0) begin : g_none
            assign hist_o = '0;
        end else if (HIST_BITS == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst)           hist_o <= '0;
                else if (shift_en) hist_o <= shift_bit;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst)           hist_o <= '0;
                else if (shift_en) hist_o <= {hist_o[HW-2:0], shift_bit};
            end
            // R5
            hist_age_chk: assert property (@(posedge clk) disable iff (rst)
                shift_en |=> hist_o[1] == $past(hist_o[0]));
        end
    endgenerate

    generate
        if (HIST_BITS > 0) begin : g_chk
            // R5
            hist_newest_chk: assert property (@(posedge clk) disable iff (rst)
                shift_en |=> hist_o[0] == $past(shift_bit));
            // R5
            hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !shift_en |=> $stable(hist_o));
        end
    endgenerate

endmodule

// File: rtl/bp_state_table.sv
module bp_state_table
    import bp_pkg::*;
#(
    parameter int N_SLOTS   = 4,
    parameter int HIST_BITS = 2,
    localparam int SLOT_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int HW      = (HIST_BITS == 0) ? 1 : HIST_BITS,
    localparam int IDX_W   = SLOT_W + HIST_BITS,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HW-1:0]     hist,
    input  logic [SLOT_W-1:0] rd_slot,
    output bp_state_t         rd_state,
    input  logic              upd_en,
    input  logic [SLOT_W-1:0] upd_slot,
    input  bp_dir_e           upd_dir,
    output bp_state_t         upd_old
);

    bp_state_t [ENTRIES-1:0] tbl;
    logic [IDX_W-1:0]        rd_idx;
    logic [IDX_W-1:0]        upd_idx;

    generate
        if (HIST_BITS == 0) begin : g_idx_flat
            assign rd_idx  = rd_slot;
            assign upd_idx = upd_slot;
        end else begin : g_idx_hist
            assign rd_idx  = {rd_slot,  hist[HIST_BITS-1:0]};
            assign upd_idx = {upd_slot, hist[HIST_BITS-1:0]};
        end
    endgenerate

    assign rd_state = tbl[rd_idx];
    assign upd_old  = tbl[upd_idx];

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst)
                    tbl[e] <= BP_INIT;
                else if (upd_en && (upd_idx == IDX_W'(e)))
                    tbl[e] <= bp_step(tbl[e], upd_dir);
            end
        end
    endgenerate

    // R1
    init_state_chk: assert property (@(posedge clk)
        rst |=> (tbl[0] == BP_INIT) && (tbl[ENTRIES-1] == BP_INIT));
    // R8
    idle_table_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(tbl));
    // R3
    sat_taken_chk: assert property (@(posedge clk) disable iff (rst)
        upd_en && (upd_dir == DIR_TAKEN) && (upd_old == 2'b01)
        |=> tbl[$past(upd_idx)] == 2'b01);
    // R4
    sat_not_taken_chk: assert property (@(posedge clk) disable iff (rst)
        upd_en && (upd_dir == DIR_NOT_TAKEN) && (upd_old == 2'b10)
        |=> tbl[$past(upd_idx)] == 2'b10);
    // R3
    leave_init_chk: assert property (@(posedge clk) disable iff (rst)
        upd_en && (upd_dir == DIR_TAKEN) && (upd_old == 2'b10)
        |=> tbl[$past(upd_idx)] == 2'b11);

endmodule

// File: rtl/bp_miss_counter.sv
module bp_miss_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)                          count <= '0;
        else if (bump && count != CNT_MAX) count <= count + 1'b1;
    end

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bump |=> $stable(count));
    // R9
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        count == CNT_MAX |=> count == CNT_MAX);

endmodule

// File: rtl/hist_branch_predictor.sv
module hist_branch_predictor
    import bp_pkg::*;
#(
    parameter int N_SLOTS   = 4,
    parameter int HIST_BITS = 2,
    parameter int CNT_W     = 16,
    localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
    localparam int HW     = (HIST_BITS == 0) ? 1 : HIST_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W-1:0] lkp_slot,
    output logic              pred_taken,
    input  logic              res_valid,
    input  logic [SLOT_W-1:0] res_slot,
    input  logic              res_taken,
    output logic [CNT_W-1:0]  miss_count
);

    logic [HW-1:0] hist;
    bp_state_t     rd_state;
    bp_state_t     upd_old;
    bp_dir_e       res_dir;
    logic          missed;

    assign res_dir = res_taken ? DIR_TAKEN : DIR_NOT_TAKEN;

    bp_history #(.HIST_BITS(HIST_BITS)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (res_valid),
        .shift_bit (res_taken),
        .hist_o    (hist)
    );

    bp_state_table #(.N_SLOTS(N_SLOTS), .HIST_BITS(HIST_BITS)) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .hist     (hist),
        .rd_slot  (lkp_slot),
        .rd_state (rd_state),
        .upd_en   (res_valid),
        .upd_slot (res_slot),
        .upd_dir  (res_dir),
        .upd_old  (upd_old)
    );

    assign pred_taken = (bp_guess(rd_state) == DIR_TAKEN);
    assign missed     = res_valid && (bp_guess(upd_old) != res_dir);

    bp_miss_counter #(.CNT_W(CNT_W)) u_miss (
        .clk   (clk),
        .rst   (rst),
        .bump  (missed),
        .count (miss_count)
    );

    // R9: a taken outcome on a fresh-state entry is always a miss
    fresh_miss_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_taken && (upd_old == BP_INIT) && !(&miss_count)
        |=> miss_count == $past(miss_count) + 1'b1);
    // R10: same-slot lookup during a resolve sees the old state
    same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid && (lkp_slot == res_slot) |-> rd_state == upd_old);

endmodule

// File: tb/hist_branch_predictor_test.sv
module hist_branch_predictor_test;

    localparam int CLK_PERIOD = 10;
    localparam int NS  = 4;
    localparam int HB  = 2;
    localparam int SETS = 1 << HB;
    localparam int CW  = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    lkp_slot;
    logic          pred_taken;
    logic          res_valid;
    logic [1:0]    res_slot;
    logic          res_taken;
    logic [CW-1:0] miss_count;

    int n_cmp = 0;
    int n_bad = 0;

    // Behavioural model: confidence level 0..3 per (slot,set); >=2 means taken
    int lvl [NS][SETS];
    int m_hist;
    int m_miss;

    always #(CLK_PERIOD/2) clk = ~clk;

    hist_branch_predictor #(.N_SLOTS(NS), .HIST_BITS(HB), .CNT_W(CW)) uut (
        .clk        (clk),
        .rst        (rst),
        .lkp_slot   (lkp_slot),
        .pred_taken (pred_taken),
        .res_valid  (res_valid),
        .res_slot   (res_slot),
        .res_taken  (res_taken),
        .miss_count (miss_count)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < NS; s++)
            for (int k = 0; k < SETS; k++) lvl[s][k] = 0;
        m_hist = 0;
        m_miss = 0;
    endtask

    // One cycle: drive, compare against the model, then advance the model
    task automatic step(input int ls, input bit rv, input int rs, input bit rt, input string tag);
        int exp_p;
        @(negedge clk);
        lkp_slot  = 2'(ls);
        res_valid = rv;
        res_slot  = 2'(rs);
        res_taken = rt;
        #1;
        exp_p = (lvl[ls][m_hist] >= 2) ? 1 : 0;
        chk(pred_taken == exp_p[0], tag, int'(pred_taken), exp_p);
        chk(int'(miss_count) == m_miss, "R9 count", int'(miss_count), m_miss);
        if (rv) begin
            if (((lvl[rs][m_hist] >= 2) ? 1 : 0) != int'(rt)) m_miss++;
            if (rt) begin
                if (lvl[rs][m_hist] < 3) lvl[rs][m_hist]++;
            end else begin
                if (lvl[rs][m_hist] > 0) lvl[rs][m_hist]--;
            end
            m_hist = ((m_hist << 1) | int'(rt)) & (SETS - 1);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        res_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; lkp_slot = '0; res_valid = 1'b0; res_slot = '0; res_taken = 1'b0;
        model_reset();
        do_reset();

        // R1: every slot predicts not-taken, count zero
        for (int s = 0; s < NS; s++) step(s, 0, 0, 0, "R1 reset guess");
        #1 chk(pred_taken == 1'b0, "R1", int'(pred_taken), 0);

        // Hand-worked sequence, history starts 00
        step(0, 1, 0, 1, "R2 first");        // slot0 set00: 10->11, miss 1, hist 01
        step(0, 1, 1, 0, "R6 set01");        // slot0 set01 fresh -> NT; hist 10
        chk(miss_count == 16'd1, "R9", int'(miss_count), 1);
        step(0, 1, 1, 0, "R6 set10");        // hist 00
        step(0, 0, 0, 0, "R3 weak nt");      // set00 = 11 -> still not-taken
        chk(pred_taken == 1'b0, "R3", int'(pred_taken), 0);
        step(0, 1, 0, 1, "R7 second");       // set00 11->00, miss 2, hist 01
        step(2, 1, 1, 0, "R8 other slot");   // slot2 untouched -> NT; hist 10
        chk(pred_taken == 1'b0, "R8", int'(pred_taken), 0);
        step(0, 1, 1, 0, "R6 set10b");       // hist 00
        step(0, 0, 0, 0, "R7 reread");       // set00 = 00 -> taken
        chk(pred_taken == 1'b1, "R7", int'(pred_taken), 1);
        chk(miss_count == 16'd2, "R9", int'(miss_count), 2);

        // Two-branch loop: slot0 alternates, slot1 always taken
        for (int i = 0; i < 24; i++) begin
            step(0, 1, 0, (i % 2) == 0, "R5 loop b1");
            step(1, 1, 1, 1'b1, "R5 loop b2");
        end

        // Saturation runs on slot3
        for (int i = 0; i < 10; i++) step(3, 1, 3, 1'b1, "R3 sat taken");
        for (int i = 0; i < 10; i++) step(3, 1, 3, 1'b0, "R4 sat not-taken");
        step(3, 0, 0, 0, "R4 floor");
        chk(pred_taken == 1'b0, "R4", int'(pred_taken), 0);

        // Pseudo-random mix, same-slot collisions frequent
        for (int i = 0; i < 3000; i++) begin
            int a, b;
            a = int'($urandom_range(0, NS - 1));
            b = ($urandom_range(0, 2) == 0) ? a : int'($urandom_range(0, NS - 1));
            step(a, $urandom_range(0, 3) != 0, b, $urandom_range(0, 2) != 0, "R10 random");
        end

        // Reset in mid-run
        do_reset();
        for (int s = 0; s < NS; s++) step(s, 0, 0, 0, "R1 re-reset");
        chk(miss_count == 16'd0, "R1", int'(miss_count), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule